// File: doc/BRIEF.md
# Miss-Recurrence Prefetcher

This block predicts conflict misses that come back at a steady rhythm, measured in misses rather than in address distance. Every demand miss line address is pushed into a shift history of recent misses. When an arriving miss finds the same address already in the history, its distance from the newest slot gives the recurrence interval k. The interval is the number of misses from the earlier occurrence up to and including the current one. The address is then entered into a small schedule table with a countdown of k. Every later miss lowers each countdown by one. Once a countdown is at or below a small lookahead, the entry is eligible for issue.

A three-state scheduler moves eligible entries to the lower memory port one at a time. In SCH_IDLE it takes the oldest eligible entry, latches its address and goes to SCH_REQ. SCH_REQ holds the request until memory accepts it, then goes to SCH_WAIT. SCH_WAIT waits for the response, writes the line into the prefetch buffer and returns to SCH_IDLE. Only one prefetch is ever in flight, so prefetches cannot collide on the port. The prefetch buffer is a small fully associative store with first-in first-out replacement. A combinational lookup port lets the cache side ask whether a line is held there.

Top module: `miss_recur_prefetch`

## Requirements
- R1: After reset no memory request is raised and every buffer lookup reports a miss.
- R2: A miss whose address appears in the history at distance k (1 ≤ k ≤ HIST_DEPTH, k = 1 for the immediately preceding miss) schedules that address. A miss with no match schedules nothing and raises no request.
- R3: A scheduled address is requested only after k − LOOKAHEAD further misses (LOOKAHEAD = 1 by default). No request is made before that.
- R4: An address that recurs after more than HIST_DEPTH (default 8) intervening pushes is not predicted. With k = 8 it is still predicted.
- R5: When several scheduled entries become eligible together, they are requested one at a time, oldest scheduled first.
- R6: A demand miss to an address already in the schedule table removes that pending entry. Any new prediction from the same miss replaces it, so the address is requested only once.
- R7: A request holds its address until accepted, and no new request is raised until the response of the previous one has arrived.
- R8: A response is written into the prefetch buffer, and a lookup of that address then hits and returns the response data.
- R9: The buffer holds BUF_DEPTH (default 4) lines. A fill into a full buffer evicts the line filled earliest.
- R10: A lookup of an address never filled reports a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | A demand miss is presented this cycle |
| miss_addr | input | ADDR_W | Line address of the demand miss |
| lkp_addr | input | ADDR_W | Line address looked up in the prefetch buffer |
| lkp_hit | output | 1 | Looked-up line is held in the buffer |
| lkp_data | output | DATA_W | Data of the looked-up line |
| mem_req_valid | output | 1 | Prefetch request to lower memory |
| mem_req_addr | output | ADDR_W | Line address of the prefetch request |
| mem_req_ready | input | 1 | Lower memory accepts the request |
| mem_rsp_valid | input | 1 | Response data for the outstanding request |
| mem_rsp_data | input | DATA_W | Response line data |

## Verification
The miss stream is driven with a repeating cycle of three addresses, which shows that predictions, countdowns and reissue work together over many misses. Further streams isolate single effects. Recurrence at distances of exactly the history depth and one beyond it tells a predicted miss from a forgotten one. Two predictions that converge on the same miss expose the issue order. A repeated miss to a pending address tells cancellation from a stale duplicate request. Pairs of back-to-back misses to five addresses fill the buffer past capacity, which separates first-in first-out eviction from any other choice of victim.

// File: rtl/mrp_pkg.sv
package mrp_pkg;

    typedef enum logic [1:0] {
        SCH_IDLE = 2'd0,
        SCH_REQ  = 2'd1,
        SCH_WAIT = 2'd2
    } sch_state_t;

endpackage

// File: rtl/mrp_history.sv
module mrp_history #(
    parameter int ADDR_W     = 16,
    parameter int HIST_DEPTH = 8,
    parameter int CNT_W      = $clog2(HIST_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [ADDR_W-1:0] push_addr,
    output logic              match,
    output logic [CNT_W-1:0]  distance
);

    logic [ADDR_W-1:0]     h_addr [HIST_DEPTH];
    logic [HIST_DEPTH-1:0] h_vld;

    // nearest earlier occurrence wins: scan from oldest towards newest
    always_comb begin
        match    = 1'b0;
        distance = '0;
        for (int i = HIST_DEPTH - 1; i >= 0; i--) begin
            if (h_vld[i] && (h_addr[i] == push_addr)) begin
                match    = 1'b1;
                distance = CNT_W'(i + 1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_vld <= '0;
            for (int i = 0; i < HIST_DEPTH; i++) h_addr[i] <= '0;
        end else if (push) begin
            h_addr[0] <= push_addr;
            for (int i = 1; i < HIST_DEPTH; i++) h_addr[i] <= h_addr[i-1];
            h_vld <= {h_vld[HIST_DEPTH-2:0], 1'b1};
        end
    end

    // R2
    distance_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match |-> (distance != '0) && (distance <= CNT_W'(HIST_DEPTH)));

endmodule

// File: rtl/mrp_sched_table.sv
module mrp_sched_table #(
    parameter int ADDR_W    = 16,
    parameter int SLOTS     = 4,
    parameter int CNT_W     = 4,
    parameter int LOOKAHEAD = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss,
    input  logic [ADDR_W-1:0] miss_addr,
    input  logic              new_ok,
    input  logic [CNT_W-1:0]  new_cnt,
    input  logic              take,
    output logic              elig,
    output logic [ADDR_W-1:0] elig_addr
);

    localparam int IW = $clog2(SLOTS);
    localparam int SW = $clog2(SLOTS + 1);

    // slot 0 is always the oldest pending entry; the table stays compacted
    logic [SLOTS-1:0]  s_vld;
    logic [ADDR_W-1:0] s_addr [SLOTS];
    logic [CNT_W-1:0]  s_cnt  [SLOTS];

    logic [SLOTS-1:0]  n_vld;
    logic [ADDR_W-1:0] n_addr [SLOTS];
    logic [CNT_W-1:0]  n_cnt  [SLOTS];
    logic [IW-1:0]     pick;
    logic [SW-1:0]     n;
    logic [SLOTS-1:0]  keep;

    always_comb begin
        elig = 1'b0;
        pick = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (s_vld[i] && (s_cnt[i] <= CNT_W'(LOOKAHEAD))) begin
                elig = 1'b1;
                pick = IW'(i);
            end
        end
        elig_addr = s_addr[pick];
    end

    always_comb begin
        n_vld  = '0;
        n_addr = s_addr;
        n_cnt  = s_cnt;
        n      = '0;
        for (int i = 0; i < SLOTS; i++) begin
            keep[i] = s_vld[i]
                    && !(take && elig && (IW'(i) == pick))
                    && !(miss && (s_addr[i] == miss_addr));
            if (keep[i]) begin
                n_addr[n[IW-1:0]] = s_addr[i];
                n_cnt[n[IW-1:0]]  = (miss && (s_cnt[i] != '0)) ? s_cnt[i] - CNT_W'(1) : s_cnt[i];
                n_vld[n[IW-1:0]]  = 1'b1;
                n = n + SW'(1);
            end
        end
        if (miss && new_ok && (n < SW'(SLOTS))) begin
            n_addr[n[IW-1:0]] = miss_addr;
            n_cnt[n[IW-1:0]]  = new_cnt;
            n_vld[n[IW-1:0]]  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_vld <= '0;
            for (int i = 0; i < SLOTS; i++) begin
                s_addr[i] <= '0;
                s_cnt[i]  <= '0;
            end
        end else begin
            s_vld  <= n_vld;
            s_addr <= n_addr;
            s_cnt  <= n_cnt;
        end
    end

    logic dup;
    always_comb begin
        dup = 1'b0;
        for (int i = 0; i < SLOTS; i++)
            for (int j = i + 1; j < SLOTS; j++)
                if (s_vld[i] && s_vld[j] && (s_addr[i] == s_addr[j])) dup = 1'b1;
    end

    // R6
    sched_unique_chk: assert property (@(posedge clk) disable iff (!rst_n) !dup);

endmodule

// File: rtl/mrp_buffer.sv
module mrp_buffer #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fill,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic [DATA_W-1:0] fill_data,
    input  logic [ADDR_W-1:0] lkp_addr,
    output logic              lkp_hit,
    output logic [DATA_W-1:0] lkp_data
);

    localparam int PW = $clog2(DEPTH);

    logic [DEPTH-1:0]  b_vld;
    logic [ADDR_W-1:0] b_addr [DEPTH];
    logic [DATA_W-1:0] b_data [DEPTH];
    logic [PW-1:0]     wptr;
    logic [DEPTH-1:0]  hvec;
    logic              f_hit;
    logic [PW-1:0]     f_idx;

    always_comb begin
        lkp_hit  = 1'b0;
        lkp_data = '0;
        f_hit    = 1'b0;
        f_idx    = '0;
        for (int i = 0; i < DEPTH; i++) begin
            hvec[i] = b_vld[i] && (b_addr[i] == lkp_addr);
            if (hvec[i]) begin
                lkp_hit  = 1'b1;
                lkp_data = b_data[i];
            end
            if (b_vld[i] && (b_addr[i] == fill_addr)) begin
                f_hit = 1'b1;
                f_idx = PW'(i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b_vld <= '0;
            wptr  <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                b_addr[i] <= '0;
                b_data[i] <= '0;
            end
        end else if (fill) begin
            if (f_hit) begin
                b_data[f_idx] <= fill_data;
            end else begin
                b_vld[wptr]  <= 1'b1;
                b_addr[wptr] <= fill_addr;
                b_data[wptr] <= fill_data;
                wptr <= (wptr == PW'(DEPTH - 1)) ? '0 : wptr + PW'(1);
            end
        end
    end

    // R8
    lookup_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(hvec));

    logic bdup;
    always_comb begin
        bdup = 1'b0;
        for (int i = 0; i < DEPTH; i++)
            for (int j = i + 1; j < DEPTH; j++)
                if (b_vld[i] && b_vld[j] && (b_addr[i] == b_addr[j])) bdup = 1'b1;
    end

    // R9
    buffer_unique_chk: assert property (@(posedge clk) disable iff (!rst_n) !bdup);

endmodule

// File: rtl/miss_recur_prefetch.sv
module miss_recur_prefetch
    import mrp_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 32,
    parameter int HIST_DEPTH = 8,
    parameter int SLOTS      = 4,
    parameter int BUF_DEPTH  = 4,
    parameter int LOOKAHEAD  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss_valid,
    input  logic [ADDR_W-1:0] miss_addr,
    input  logic [ADDR_W-1:0] lkp_addr,
    output logic              lkp_hit,
    output logic [DATA_W-1:0] lkp_data,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_req_ready,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data
);

    localparam int CNT_W = $clog2(HIST_DEPTH + 1);

    logic              h_match;
    logic [CNT_W-1:0]  h_dist;
    logic              elig;
    logic [ADDR_W-1:0] elig_addr;
    logic              take;
    logic              fill;
    logic [ADDR_W-1:0] pf_addr;
    sch_state_t        state, nxt;

    mrp_history #(.ADDR_W(ADDR_W), .HIST_DEPTH(HIST_DEPTH), .CNT_W(CNT_W)) u_hist (
        .clk(clk), .rst_n(rst_n), .push(miss_valid), .push_addr(miss_addr),
        .match(h_match), .distance(h_dist)
    );

    mrp_sched_table #(.ADDR_W(ADDR_W), .SLOTS(SLOTS), .CNT_W(CNT_W), .LOOKAHEAD(LOOKAHEAD)) u_sched (
        .clk(clk), .rst_n(rst_n), .miss(miss_valid), .miss_addr(miss_addr),
        .new_ok(h_match), .new_cnt(h_dist), .take(take),
        .elig(elig), .elig_addr(elig_addr)
    );

    mrp_buffer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(BUF_DEPTH)) u_buf (
        .clk(clk), .rst_n(rst_n), .fill(fill), .fill_addr(pf_addr), .fill_data(mem_rsp_data),
        .lkp_addr(lkp_addr), .lkp_hit(lkp_hit), .lkp_data(lkp_data)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= SCH_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            SCH_IDLE: if (elig)          nxt = SCH_REQ;
            SCH_REQ:  if (mem_req_ready) nxt = SCH_WAIT;
            SCH_WAIT: if (mem_rsp_valid) nxt = SCH_IDLE;
            default:                     nxt = SCH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)    pf_addr <= '0;
        else if (take) pf_addr <= elig_addr;
    end

    // outputs
    always_comb begin
        take          = (state == SCH_IDLE) && elig;
        mem_req_valid = (state == SCH_REQ);
        mem_req_addr  = pf_addr;
        fill          = (state == SCH_WAIT) && mem_rsp_valid;
    end

    // R7
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R7
    single_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_ready) |=> !mem_req_valid);

endmodule

// File: tb/test_miss_recur_prefetch.sv
module test_miss_recur_prefetch;

    localparam int AW = 16;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          miss_valid = 1'b0;
    logic [AW-1:0] miss_addr = '0;
    logic [AW-1:0] lkp_addr = '0;
    logic          lkp_hit;
    logic [DW-1:0] lkp_data;
    logic          mem_req_valid;
    logic [AW-1:0] mem_req_addr;
    logic          mem_req_ready = 1'b0;
    logic          mem_rsp_valid = 1'b0;
    logic [DW-1:0] mem_rsp_data = '0;

    int nchk = 0;
    int nerr = 0;
    int nreq = 0;
    int cyc  = 0;
    logic [AW-1:0] exp_q[$];
    logic [AW-1:0] fr = 16'h4000;

    always #4 clk = ~clk;

    miss_recur_prefetch i_miss_recur_prefetch (
        .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_addr(miss_addr),
        .lkp_addr(lkp_addr), .lkp_hit(lkp_hit), .lkp_data(lkp_data),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr), .mem_req_ready(mem_req_ready),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

    function automatic logic [DW-1:0] fdata(input logic [AW-1:0] a);
        return {a ^ 16'h5A5A, a};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // memory model and scoreboard monitor
    logic          pend = 1'b0;
    int            pdly = 0;
    logic [AW-1:0] paddr = '0;
    always @(negedge clk) begin
        cyc++;
        mem_rsp_valid = 1'b0;
        if (pend) begin
            if (pdly == 0) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = fdata(paddr);
                pend = 1'b0;
            end else pdly--;
        end
        mem_req_ready = (cyc % 3) != 1;
        if (rst_n && mem_req_valid && mem_req_ready) begin
            nreq++;
            pend  = 1'b1;
            pdly  = 2;
            paddr = mem_req_addr;
            if (exp_q.size() == 0) begin
                check(1'b0, "R5/R6 unexpected prefetch request", 64'(mem_req_addr), 64'hFFFF_FFFF);
            end else begin
                logic [AW-1:0] e;
                e = exp_q.pop_front();
                check(mem_req_addr == e, "R3/R5 prefetch address order", 64'(mem_req_addr), 64'(e));
            end
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        miss_valid = 1'b0;
        exp_q.delete();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        nreq = 0;
    endtask

    task automatic miss(input logic [AW-1:0] a);
        @(negedge clk);
        miss_valid = 1'b1;
        miss_addr  = a;
        @(negedge clk);
        miss_valid = 1'b0;
        repeat (14) @(negedge clk);
    endtask

    task automatic miss_fresh(input int n);
        for (int i = 0; i < n; i++) begin
            fr = fr + 16'd1;
            miss(fr);
        end
    endtask

    task automatic expect_req(input logic [AW-1:0] a);
        exp_q.push_back(a);
    endtask

    task automatic drain(input string tag);
        repeat (24) @(negedge clk);
        check(exp_q.size() == 0, tag, 64'(exp_q.size()), 64'd0);
    endtask

    task automatic look(input logic [AW-1:0] a, input bit eh, input string tag);
        @(negedge clk);
        lkp_addr = a;
        #1;
        check(lkp_hit == eh, tag, 64'(lkp_hit), 64'(eh));
        if (eh) check(lkp_data == fdata(a), tag, 64'(lkp_data), 64'(fdata(a)));
    endtask

    bit finished = 1'b0;

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        do_reset();
        @(negedge clk);
        check(mem_req_valid == 1'b0, "R1 no request after reset", 64'(mem_req_valid), 64'd0);
        look(16'h00A0, 1'b0, "R1 buffer empty after reset");

        // R2 / R8 / R10: repeating cycle A B C
        do_reset();
        miss(16'h00A0); miss(16'h00B0); miss(16'h00C0);
        check(nreq == 0, "R2 unmatched misses raise nothing", 64'(nreq), 64'd0);
        expect_req(16'h00A0);
        expect_req(16'h00B0);
        miss(16'h00A0); miss(16'h00B0); miss(16'h00C0); miss(16'h00A0);
        drain("R2 predicted requests issued");
        check(nreq == 2, "R2 request count for cycle", 64'(nreq), 64'd2);
        look(16'h00A0, 1'b1, "R8 filled line A hits");
        look(16'h00B0, 1'b1, "R8 filled line B hits");
        look(16'h00C0, 1'b0, "R10 unfilled line misses");

        // R3 lookahead boundary, k = 4
        do_reset();
        miss(16'h0E00); miss(16'h0F00); miss(16'h0F10); miss(16'h0F20); miss(16'h0E00);
        miss_fresh(1);
        check(nreq == 0, "R3 not issued after 1 of 3 misses", 64'(nreq), 64'd0);
        miss_fresh(1);
        check(nreq == 0, "R3 not issued after 2 of 3 misses", 64'(nreq), 64'd0);
        expect_req(16'h0E00);
        miss_fresh(1);
        drain("R3 issued after 3 misses");
        check(nreq == 1, "R3 single request", 64'(nreq), 64'd1);

        // R6 cancellation
        do_reset();
        miss(16'h0100); miss(16'h0110); miss(16'h0120); miss(16'h0130); miss(16'h0100);
        expect_req(16'h0100);
        miss(16'h0100);
        drain("R6 re-predicted request");
        miss_fresh(3);
        drain("R6 no stale request");
        check(nreq == 1, "R6 pending entry cancelled", 64'(nreq), 64'd1);

        // R5 oldest first
        do_reset();
        miss(16'h0200); miss(16'h0210); miss(16'h0220); miss(16'h0200); miss(16'h0220);
        check(nreq == 0, "R5 none eligible yet", 64'(nreq), 64'd0);
        expect_req(16'h0200);
        expect_req(16'h0220);
        miss_fresh(1);
        drain("R5 both issued oldest first");
        check(nreq == 2, "R5 two requests", 64'(nreq), 64'd2);

        // R4 history depth boundary
        do_reset();
        miss(16'h0300);
        miss_fresh(7);
        miss(16'h0300);
        miss_fresh(6);
        check(nreq == 0, "R4 k=8 not yet due", 64'(nreq), 64'd0);
        expect_req(16'h0300);
        miss_fresh(1);
        drain("R4 k=8 predicted");
        miss(16'h0310);
        miss_fresh(8);
        miss(16'h0310);
        miss_fresh(9);
        drain("R4 k=9 not predicted");
        check(nreq == 1, "R4 beyond depth forgotten", 64'(nreq), 64'd1);

        // R9 first-in first-out replacement
        do_reset();
        for (int i = 0; i < 5; i++) begin
            logic [AW-1:0] a;
            a = 16'h0500 + 16'(i * 16);
            expect_req(a);
            miss(a);
            miss(a);
        end
        drain("R9 five fills requested");
        look(16'h0500, 1'b0, "R9 earliest fill evicted");
        for (int i = 1; i < 5; i++) begin
            look(16'h0500 + 16'(i * 16), 1'b1, "R9 later fills retained");
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule